// File: doc/BRIEF.md
# PAM4 Transmit Feed-Forward Equalizer

This block is the digital pre-distortion stage of a four-level pulse-amplitude transmitter. Each clock cycle is one unit interval. In every cycle the block takes one 2-bit symbol and turns it into a signed level. It then forms a weighted sum of that level and the three previous levels, and registers the sum as the drive word for a DAC. Two taps act on symbols that come later than the main cursor, and one tap acts on a symbol that came earlier.

Software never sets the main-cursor weight directly. It writes three small signed codes and one shared step size. Each side weight is its code multiplied by the step, and a tap whose code has the wrong sign is forced to zero. The main weight is then one minus the sum of the side-weight magnitudes, so the total drive stays at unity. If the side taps ask for more than unity, the main weight floors at zero and a sticky flag is raised.

Writes go to shadow registers first. A separate commit write moves all of them into the active set in a single cycle.

Top module: `pam4_ffe_tx`

## Requirements
- R1: Symbol codes map to levels as follows: 2'b00 to -3, 2'b01 to -1, 2'b10 to +1 and 2'b11 to +3.
- R2: `level_o` is the sum of four products, each a weight times a level. The far pre-cursor weight multiplies the newest level, x[n]. The near pre-cursor weight multiplies x[n-1], the main weight multiplies x[n-2] and the post-cursor weight multiplies x[n-3]. A symbol enters x[n] at the edge that samples it, and `level_o` is registered one edge later.
- R3: Weights are in units of 1/256, so unity is 256. Each side weight equals its signed two's-complement code (CODE_W bits) multiplied by the unsigned step (STEP_W bits).
- R4: The main weight equals 256 minus the sum of the absolute values of the three side weights.
- R5: The far pre-cursor code is clamped to 0 when it is negative. The near pre-cursor and post-cursor codes are clamped to 0 when they are positive.
- R6: When the side magnitudes sum to more than 256, the main weight is 0 and `sat_err_o` rises one edge after the commit. It then stays high until reset. A sum of exactly 256 gives a main weight of 0 and no error.
- R7: Writes to address 0 (step), 1 (far pre-cursor code), 2 (near pre-cursor code) and 3 (post-cursor code) change nothing at the output. A write to address 4 loads all four weights at one edge, so no output word combines old and new weights.
- R8: After reset the level history is zero, `level_o` is 0, `sat_err_o` is 0, the main weight is 256 and every side weight is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 2 | PAM4 symbol for this UI |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register address, 0 to 3 shadow, 4 commit |
| cfg_wdata | input | max(CODE_W,STEP_W) | Write data |
| level_o | output | CODE_W+STEP_W+6 | Signed equalized drive word |
| sat_err_o | output | 1 | Sticky side-tap overflow flag |

## Verification
The assertions assume that the clock never stops between reset and the end of the run. They also assume that a symbol is present in every cycle, because the history register takes a new value at every edge. The bench keeps inside these assumptions. Its driver task sets a symbol on every falling edge, starting at the falling edge where reset is released. Configuration writes ride along with symbols and never replace one. Codes are written as CODE_W-bit two's complement values within range, including values of the wrong sign and sums at exactly unity and just above it.

// File: rtl/pam4_ffe_tx.sv
`timescale 1ns/1ps
module pam4_ffe_tx #(
  parameter int CODE_W = 6,
  parameter int STEP_W = 6,
  parameter int FRAC_W = 8
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic [1:0]                                        sym_i,
  input  logic                                              cfg_we,
  input  logic [2:0]                                        cfg_addr,
  input  logic [((CODE_W > STEP_W) ? CODE_W : STEP_W)-1:0] cfg_wdata,
  output logic signed [CODE_W+STEP_W+5:0]                   level_o,
  output logic                                              sat_err_o
);
  localparam int W_W   = CODE_W + STEP_W + 1;
  localparam int OUT_W = W_W + 5;
  localparam int SUM_W = W_W + 2;
  localparam int UNITY = 1 << FRAC_W;
  localparam logic [2:0] A_STEP = 3'd0, A_PRE2 = 3'd1, A_PRE1 = 3'd2,
                         A_POST = 3'd3, A_COMMIT = 3'd4;

  logic [STEP_W-1:0]        stg_step;
  logic signed [CODE_W-1:0] stg_pre2, stg_pre1, stg_post;
  logic signed [W_W-1:0]    w_pre2, w_pre1, w_main, w_post;
  logic signed [2:0]        hist [4];

  function automatic logic signed [W_W-1:0] tap_weight(
    input logic signed [CODE_W-1:0] code, input logic [STEP_W-1:0] step);
    logic signed [W_W-1:0] cx, sx;
    cx = W_W'(code);
    sx = $signed({{(W_W-STEP_W){1'b0}}, step});
    return cx * sx;
  endfunction

  logic signed [CODE_W-1:0] cl_pre2, cl_pre1, cl_post;
  assign cl_pre2 = stg_pre2[CODE_W-1] ? '0 : stg_pre2;
  assign cl_pre1 = stg_pre1[CODE_W-1] ? stg_pre1 : '0;
  assign cl_post = stg_post[CODE_W-1] ? stg_post : '0;

  logic signed [W_W-1:0] n_pre2, n_pre1, n_post, n_main;
  logic [SUM_W-1:0]      mag_sum;
  logic                  over;

  assign n_pre2  = tap_weight(cl_pre2, stg_step);
  assign n_pre1  = tap_weight(cl_pre1, stg_step);
  assign n_post  = tap_weight(cl_post, stg_step);
  assign mag_sum = SUM_W'($unsigned(n_pre2)) + SUM_W'($unsigned(-n_pre1))
                 + SUM_W'($unsigned(-n_post));
  assign over    = mag_sum > SUM_W'(UNITY);
  assign n_main  = over ? '0 : W_W'(SUM_W'(UNITY) - mag_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_step <= '0;
      stg_pre2 <= '0;
      stg_pre1 <= '0;
      stg_post <= '0;
      w_pre2   <= '0;
      w_pre1   <= '0;
      w_post   <= '0;
      w_main   <= W_W'(UNITY);
      sat_err_o <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_STEP: stg_step <= cfg_wdata[STEP_W-1:0];
        A_PRE2: stg_pre2 <= $signed(cfg_wdata[CODE_W-1:0]);
        A_PRE1: stg_pre1 <= $signed(cfg_wdata[CODE_W-1:0]);
        A_POST: stg_post <= $signed(cfg_wdata[CODE_W-1:0]);
        A_COMMIT: begin
          w_pre2 <= n_pre2;
          w_pre1 <= n_pre1;
          w_post <= n_post;
          w_main <= n_main;
          if (over) sat_err_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  logic signed [3:0] lvl_in;
  assign lvl_in = $signed({1'b0, sym_i, 1'b1}) - 4'sd4;

  logic signed [OUT_W-1:0] acc;
  assign acc = OUT_W'(w_pre2) * OUT_W'(hist[0]) + OUT_W'(w_pre1) * OUT_W'(hist[1])
             + OUT_W'(w_main) * OUT_W'(hist[2]) + OUT_W'(w_post) * OUT_W'(hist[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hist[i] <= '0;
      level_o <= '0;
    end else begin
      hist[0] <= lvl_in[2:0];
      for (int i = 1; i < 4; i++) hist[i] <= hist[i-1];
      level_o <= acc;
    end
  end

  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (hist[0] == 3'sd3 || hist[0] == 3'sd1 ||
                      hist[0] == -3'sd1 || hist[0] == -3'sd3)); // R1
  AST_SIGN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (w_pre2 >= 0) && (w_pre1 <= 0) && (w_post <= 0)); // R5
  AST_UNITY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (w_main != 0) |-> (int'(w_main) + int'(w_pre2) - int'(w_pre1) - int'(w_post) == UNITY)); // R4
  AST_NO_EARLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == A_COMMIT) |=>
      ($stable(w_pre2) && $stable(w_pre1) && $stable(w_main) && $stable(w_post))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sat_err_o |=> sat_err_o); // R6
  AST_ERR_MAIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_err_o) |-> (w_main == 0)); // R6
endmodule

// File: tb/sim_pam4_ffe_tx.sv
`timescale 1ns/1ps
module sim_pam4_ffe_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sym_i = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [5:0] cfg_wdata = '0;
  logic signed [17:0] level_o;
  logic sat_err_o;

  pam4_ffe_tx u0 (.clk(clk), .rst_n(rst_n), .sym_i(sym_i), .cfg_we(cfg_we),
                  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
                  .level_o(level_o), .sat_err_o(sat_err_o));

  always #4 clk = ~clk;

  typedef struct { int exp; int due; string tag; } item_t;
  item_t q[$];
  int total = 0, bad = 0, cnt = 0;
  int s_step = 0, s_p2 = 0, s_p1 = 0, s_po = 0;
  int a_p2 = 0, a_p1 = 0, a_m = 256, a_po = 0;
  int h[4] = '{0, 0, 0, 0};
  string cur_tag = "R1";
  bit done = 0;

  always @(posedge clk) cnt <= cnt + 1;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sx6(int d);
    return (d >= 32) ? d - 64 : d;
  endfunction

  task automatic commit_model();
    int c2, c1, cp, sum;
    c2 = (s_p2 < 0) ? 0 : s_p2;
    c1 = (s_p1 > 0) ? 0 : s_p1;
    cp = (s_po > 0) ? 0 : s_po;
    a_p2 = c2 * s_step; a_p1 = c1 * s_step; a_po = cp * s_step;
    sum = a_p2 - a_p1 - a_po;
    a_m = (sum > 256) ? 0 : 256 - sum;
  endtask

  task automatic ui(int sym, bit we = 0, int addr = 0, int data = 0);
    item_t it;
    sym_i = 2'(sym); cfg_we = we; cfg_addr = 3'(addr); cfg_wdata = 6'(data);
    if (we) begin
      case (addr)
        0: s_step = data;
        1: s_p2 = sx6(data);
        2: s_p1 = sx6(data);
        3: s_po = sx6(data);
        4: commit_model();
        default: ;
      endcase
    end
    h[3] = h[2]; h[2] = h[1]; h[1] = h[0]; h[0] = 2 * sym - 3;
    it.exp = a_p2 * h[0] + a_p1 * h[1] + a_m * h[2] + a_po * h[3];
    it.due = cnt + 2;
    it.tag = cur_tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic run(int n, int seed);
    for (int i = 0; i < n; i++) ui((i * seed + i / 3) % 4);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cnt) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, int'(level_o), it.exp);
    end
  end

  initial begin
    #1_600_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8 level", int'(level_o), 0);
    check("R8 err", int'(sat_err_o), 0);
    cur_tag = "R8";
    ui(3); ui(3); ui(3);
    cur_tag = "R1";
    ui(0); ui(1); ui(2); ui(3); ui(0); ui(3); ui(1); ui(2);
    cur_tag = "R2";
    run(12, 3);
    cur_tag = "R7";
    ui(1, 1, 0, 8); ui(2, 1, 1, 3); ui(0, 1, 2, -5); ui(3, 1, 3, -4); ui(2); ui(1);
    cur_tag = "R3";
    ui(0, 1, 4, 0);
    check("R4 err", int'(sat_err_o), 0);
    run(16, 5);
    cur_tag = "R4";
    ui(3, 1, 0, 12); ui(2, 1, 2, -9); ui(1, 1, 4, 0);
    run(12, 7);
    cur_tag = "R5";
    ui(1, 1, 1, -2); ui(0, 1, 2, 4); ui(3, 1, 3, 7); ui(2, 1, 4, 0);
    run(12, 1);
    cur_tag = "R6";
    ui(1, 1, 0, 16); ui(2, 1, 1, 4); ui(3, 1, 2, -8); ui(0, 1, 3, -4); ui(1, 1, 4, 0);
    run(8, 3);
    check("R6 exact unity err", int'(sat_err_o), 0);
    ui(2, 1, 3, -5); ui(3, 1, 4, 0);
    check("R6 err rise", int'(sat_err_o), 1);
    run(8, 5);
    ui(0, 1, 0, 2); ui(1, 1, 4, 0);
    run(6, 1);
    check("R6 err sticky", int'(sat_err_o), 1);
    cur_tag = "R7";
    ui(2, 1, 1, 31); ui(3, 1, 0, 30); run(6, 7);
    ui(0); ui(0); ui(0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule